// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

The block arbitrates up to sixteen interrupt sources. Each source has its own pending flag, an enable bit and a 3-bit programmable level. A one-cycle pulse on a request line sets that source's pending flag. An acknowledge strobe with a source index clears it again. On every cycle the block picks one winner from the sources that are both pending and enabled. The higher level wins. When levels are equal, the lower source index wins.

The winner's level is compared with a 3-bit CPU mask level. The CPU request output goes high only when the winner's level is strictly greater than the mask. The winner's index and level are reported on every cycle in which any candidate exists, even when the mask holds the request back. Software reaches the enable register and the level registers through a simple bus: address, write strobe and write data, with read data returned combinationally.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable register and every level field read 0, and `irq_o`, `irq_id_o` and `irq_lvl_o` are 0.
- R2: Address 0 is the enable register. A write stores all 16 bits and a read returns them. Bit n set to 1 enables source n; bit n at 0 disables it.
- R3: Addresses 1 to 4 are the level registers. Address 1+k holds sources 4k to 4k+3. Source 4k+j occupies bits [4j+2:4j]. Bits 15, 11, 7 and 3 ignore writes and read as 0.
- R4: A pulse on `req_i[n]` sets pending flag n at the next edge. If an acknowledge of source n arrives in the same cycle, the set wins and the flag stays 1.
- R5: A strobe on `ack_i` clears the pending flag of source `ack_id_i` at the next edge.
- R6: A disabled source never takes part in arbitration, but its pending flag is kept. Once it is enabled, it competes.
- R7: Among enabled pending sources, the one with the numerically highest level wins (7 is highest, 0 is lowest).
- R8: When several candidates share the top level, the lowest source index wins.
- R9: `irq_o` is 1 only when the winner's level is strictly greater than `mask_i`. At equal level and mask, `irq_o` is 0.
- R10: A winner at level 0 never raises `irq_o`.
- R11: `irq_id_o` and `irq_lvl_o` give the winner whenever a candidate exists, and are 0 when none exists. All three outputs are registered and follow a change of pending, enable, level or mask one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| req_i | input | 16 | Per-source one-cycle request pulses |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 4 | Source index being acknowledged |
| mask_i | input | 3 | CPU mask level |
| irq_o | output | 1 | Request to the CPU |
| irq_id_o | output | 4 | Winning source index |
| irq_lvl_o | output | 3 | Winning source level |

## Verification
The bench makes a source pending while it is disabled, then enables it. A design that drops the flag would stay silent after the enable, and one that ignores the enable would report the source too early. It sets two sources to the same level at different indices, and also sets the mask equal to the winner's level. Those cases catch a reversed tie-break and a greater-or-equal compare, which would raise a request that must stay low. It also checks a level-0 source with mask 0, a request and an acknowledge on the same source in the same cycle, reserved bits written as ones, and that a mask change shows up on the outputs exactly one edge later.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_EN    = 0;
  localparam int PRIO_BASE  = 1;
  localparam int FLD_STRIDE = 4;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [N_SRC-1:0]         en_o,
  output logic [N_SRC*LVL_W-1:0]   lvl_o
);
  localparam int FPR    = DATA_W / FLD_STRIDE;
  localparam int N_PREG = (N_SRC + FPR - 1) / FPR;

  logic [N_SRC-1:0] en_q;
  logic [LVL_W-1:0] lvl_q [N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      for (int i = 0; i < N_SRC; i++) lvl_q[i] <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(ADDR_EN)) en_q <= wdata_i[N_SRC-1:0];
      for (int k = 0; k < N_PREG; k++) begin
        if (addr_i == ADDR_W'(PRIO_BASE + k)) begin
          for (int j = 0; j < FPR; j++) begin
            if (k*FPR + j < N_SRC)
              lvl_q[k*FPR + j] <= wdata_i[j*FLD_STRIDE +: LVL_W];
          end
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_EN)) rdata_o[N_SRC-1:0] = en_q;
    for (int k = 0; k < N_PREG; k++) begin
      if (addr_i == ADDR_W'(PRIO_BASE + k)) begin
        for (int j = 0; j < FPR; j++) begin
          if (k*FPR + j < N_SRC)
            rdata_o[j*FLD_STRIDE +: LVL_W] = lvl_q[k*FPR + j];
        end
      end
    end
  end

  assign en_o = en_q;
  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    assign lvl_o[g*LVL_W +: LVL_W] = lvl_q[g];
  end

  // R2: enable write lands next cycle
  assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(ADDR_EN)) |=> (en_o == $past(wdata_i[N_SRC-1:0])));
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int N_SRC = 16,
  parameter int ID_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             ack_i,
  input  logic [ID_W-1:0]  ack_id_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] clr;

  always_comb begin
    clr = '0;
    if (ack_i) clr[ack_id_i] = 1'b1;
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | req_i;
  end

  assign pend_o = pend_q;

  assert_req_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((pend_o & $past(req_i)) == $past(req_i)));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_i[ack_id_i]) |=> !pend_o[$past(ack_id_i)]);
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N_SRC = 16,
  parameter int LVL_W = 3,
  parameter int ID_W  = 4
) (
  input  logic [N_SRC-1:0]       cand_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic                   found_o,
  output logic [ID_W-1:0]        id_o,
  output logic [LVL_W-1:0]       lvl_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!found_o || lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
        lvl_o   = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  assert_winner_is_cand_R6: assert final (!found_o || cand_i[id_o]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC  = 16,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              ack_i,
  input  logic [ID_W-1:0]   ack_id_i,
  input  logic [LVL_W-1:0]  mask_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  logic [N_SRC-1:0]       en;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic [N_SRC-1:0]       pend;
  logic                   found;
  logic [ID_W-1:0]        win_id;
  logic [LVL_W-1:0]       win_lvl;

  prio_irq_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .en_o(en), .lvl_o(lvl_flat)
  );

  prio_irq_pend #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pend (
    .clk_i, .rst_ni, .req_i, .ack_i, .ack_id_i, .pend_o(pend)
  );

  prio_irq_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .cand_i(pend & en), .lvl_i(lvl_flat), .found_o(found), .id_o(win_id), .lvl_o(win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_id_o  <= '0;
      irq_lvl_o <= '0;
    end else begin
      irq_o     <= found && (win_lvl > mask_i);
      irq_id_o  <= win_id;
      irq_lvl_o <= win_lvl;
    end
  end

  assert_irq_above_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o > $past(mask_i)));

  assert_no_lvl0_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o != '0));

  assert_mask_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found && win_lvl <= mask_i) |=> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  addr = 0;
  logic        we = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [15:0] req = 0;
  logic        ack = 0;
  logic [3:0]  ack_id = 0;
  logic [2:0]  mask = 0;
  logic        irq;
  logic [3:0]  irq_id;
  logic [2:0]  irq_lvl;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .req_i(req), .ack_i(ack), .ack_id_i(ack_id), .mask_i(mask),
    .irq_o(irq), .irq_id_o(irq_id), .irq_lvl_o(irq_lvl)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, logic e_irq, logic [3:0] e_id, logic [2:0] e_lvl);
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, e_irq});
    chk({tag, " id"},  {12'd0, irq_id}, {12'd0, e_id});
    chk({tag, " lvl"}, {13'd0, irq_lvl}, {13'd0, e_lvl});
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    req[n] = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic do_ack(int n);
    @(negedge clk);
    ack = 1; ack_id = 4'(n);
    @(negedge clk);
    ack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_out("R1 reset", 0, 0, 0);
    rd(0, d); chk("R1 en reset", d, 16'h0000);
    for (int k = 1; k <= 4; k++) begin
      rd(3'(k), d); chk("R1 lvl reset", d, 16'h0000);
    end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(0, 16'hA5C3); rd(0, d); chk("R2 en rw", d, 16'hA5C3);
    wr(1, 16'hFFFF); rd(1, d); chk("R3 reserved", d, 16'h7777);
    wr(2, 16'h1234); rd(2, d); chk("R3 fields", d, 16'h1234);
    rd(1, d); chk("R3 no alias", d, 16'h7777);
    wr(0, 0); wr(1, 0); wr(2, 0);
  endtask

  task automatic t_disabled();
    wr(2, 16'h0040);                // source 5 level 4
    pulse(5); settle();
    chk_out("R6 disabled", 0, 0, 0);
    wr(0, 16'h0020); settle();
    chk_out("R6 enabled", 1, 5, 4);
  endtask

  task automatic t_prio();
    wr(3, 16'h0060);                // source 9 level 6
    wr(0, 16'h0220);
    pulse(9); settle();
    chk_out("R7 higher", 1, 9, 6);
  endtask

  task automatic t_tie();
    wr(1, 16'h0600);                // source 2 level 6
    wr(0, 16'h0224);
    pulse(2); settle();
    chk_out("R8 tie", 1, 2, 6);
  endtask

  task automatic t_mask();
    @(negedge clk); mask = 6; settle();
    chk_out("R9 equal", 0, 2, 6);
    @(negedge clk); mask = 5;
    @(posedge clk); #1;
    chk_out("R11 one edge", 1, 2, 6);
    @(negedge clk); mask = 7;
    @(posedge clk); #1;
    chk_out("R11 mask up", 0, 2, 6);
    @(negedge clk); mask = 0;
  endtask

  task automatic t_ack();
    do_ack(2); settle(); chk_out("R5 ack2", 1, 9, 6);
    do_ack(9); settle(); chk_out("R5 ack9", 1, 5, 4);
    do_ack(5); settle(); chk_out("R11 none", 0, 0, 0);
  endtask

  task automatic t_level0();
    wr(0, 16'h1000);                // source 12 level 0
    pulse(12); settle();
    chk_out("R10 lvl0", 0, 12, 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    req[12] = 1; ack = 1; ack_id = 12;
    @(negedge clk);
    req = 0; ack = 0;
    settle();
    chk_out("R4 set wins", 0, 12, 0);
    do_ack(12); settle();
    chk_out("R5 cleared", 0, 0, 0);
  endtask

  initial begin
    #(3*CLK_PERIOD) rst_n = 1;
    #1;
    t_reset();
    t_regs();
    t_disabled();
    t_prio();
    t_tie();
    t_mask();
    t_ack();
    t_level0();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000*CLK_PERIOD);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule